// File: doc/BRIEF.md
# Multichannel Converter Channel Sequencer

This block is the digital control core of a four-input data converter. It holds one control word, written over a parallel port, that fixes the input configuration (four single inputs or two input pairs), the sequencing mode and a channel address. From that word it drives the multiplexer select and a pair flag, and it decides which channel each conversion samples.

There are two ways of choosing channels. In manual mode the host writes the address before each conversion, and every write picks the channel for the next one. In sweep mode a write restarts a scan at channel 0. Each finished conversion then moves the select up by one until the programmed final channel has been converted, and the scan wraps back to 0 and repeats until the next write. The converter itself is represented only by a start strobe and a done strobe. On each done the block reports which channel was just converted, so results can be tagged.

Top module: `adc_chan_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, mux_sel is 0, mux_pair is 0 and done_valid is 0.
- R2: The control word has the address in bits [1:0], the sequence code in bits [3:2] and the configuration code in bits [5:4]. A configuration with bit 4 at 1 and bit 5 at 0 selects pair mode, and mux_pair is then 1. Every other configuration selects single inputs with mux_pair at 0. In pair mode mux_sel never exceeds 1.
- R3: With sequence code 00, the cycle after a write takes effect, mux_sel equals the address. In pair mode it equals address bit 0.
- R4: Sequence codes 01 and 10 behave exactly like 00.
- R5: With sequence code 11, mux_sel is 0 the cycle after a write takes effect. Each accepted conversion-done moves it up by one. After the final channel (the address, or address bit 0 in pair mode) it wraps to 0.
- R6: In manual mode an accepted conversion-done leaves mux_sel unchanged.
- R7: conv_start while idle begins a conversion that lasts until conv_done. conv_start during a conversion is ignored. conv_done while idle is ignored: it produces no tag and does not move mux_sel.
- R8: A write during a conversion leaves mux_sel and mux_pair unchanged until that conversion's done. It takes effect in the cycle after the done, and the last such write wins.
- R9: The cycle after an accepted conversion-done, done_valid is high for one cycle. done_chan then holds the mux_sel used during that conversion, and done_pair holds the pair flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word: config [5:4], sequence [3:2], address [1:0] |
| conv_start | input | 1 | Conversion start strobe |
| conv_done | input | 1 | Conversion done strobe |
| mux_sel | output | 2 | Channel or pair index presented to the multiplexer |
| mux_pair | output | 1 | 1 when mux_sel addresses a pair |
| done_valid | output | 1 | One-cycle pulse after an accepted done |
| done_chan | output | 2 | Channel just converted |
| done_pair | output | 1 | Pair flag of the channel just converted |

## Verification
The assertions check on every cycle that the select holds through a conversion, that the pair index stays in range, that stray done strobes are ignored, and that each tag is a single pulse carrying the select that was in use. Whether the select holds the right value can only be shown by the bench's scenarios and its per-cycle reference model. This covers the sweep order and its wrap point in both configurations, the reserved sequence codes, and which of several writes made during a conversion is the one that wins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_IN    = 4;
    localparam int NUM_PAIRS = NUM_IN / 2;
    localparam int CH_W      = $clog2(NUM_IN);
    localparam int WORD_W    = CH_W + 4;

    typedef enum logic [1:0] {
        SEQ_MANUAL = 2'b00,
        SEQ_ALT_A  = 2'b01,
        SEQ_ALT_B  = 2'b10,
        SEQ_SWEEP  = 2'b11
    } seq_code_e;

    // packed MSB first: cfg [5:4], seq [3:2], addr [1:0]
    typedef struct packed {
        logic [1:0]      cfg;
        seq_code_e       seq;
        logic [CH_W-1:0] addr;
    } ctrl_word_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
        logic            pair;
    } chan_tag_t;

    function automatic logic is_pair(ctrl_word_t w);
        return w.cfg == 2'b01;
    endfunction

    function automatic logic is_sweep(ctrl_word_t w);
        return w.seq == SEQ_SWEEP;
    endfunction

    function automatic logic [CH_W-1:0] chan_limit(ctrl_word_t w);
        return is_pair(w) ? CH_W'(NUM_PAIRS - 1) : CH_W'(NUM_IN - 1);
    endfunction

    function automatic logic [CH_W-1:0] start_chan(ctrl_word_t w);
        return is_sweep(w) ? '0 : (w.addr & chan_limit(w));
    endfunction

    function automatic logic [CH_W-1:0] step_chan(ctrl_word_t w, logic [CH_W-1:0] cur);
        logic [CH_W-1:0] fin;
        fin = w.addr & chan_limit(w);
        return (cur == fin) ? '0 : CH_W'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/adc_seq_conv_track.sv
module adc_seq_conv_track (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    input  logic conv_done,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (busy)
            busy <= !conv_done;
        else
            busy <= conv_start;
    end
endmodule

// File: rtl/adc_seq_ctrl_reg.sv
module adc_seq_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_word_t wr_word,
    input  logic       busy,
    input  logic       conv_done,
    output ctrl_word_t active,
    output logic       apply,
    output ctrl_word_t apply_word,
    output logic       pend_valid
);
    ctrl_word_t pend_q;

    always_comb begin
        apply      = busy ? (conv_done && (wr_en || pend_valid)) : wr_en;
        apply_word = wr_en ? wr_word : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= '0;
            pend_q     <= '0;
            pend_valid <= 1'b0;
        end else begin
            if (apply)
                active <= apply_word;
            if (busy && !conv_done && wr_en) begin
                pend_q     <= wr_word;
                pend_valid <= 1'b1;
            end else if (busy && conv_done) begin
                pend_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_seq_ptr.sv
module adc_seq_ptr
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            apply,
    input  ctrl_word_t      apply_word,
    input  ctrl_word_t      active,
    input  logic            busy,
    input  logic            conv_done,
    output logic [CH_W-1:0] sel,
    output chan_tag_t       tag
);
    logic accept_done;
    assign accept_done = busy && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            tag <= '0;
        end else begin
            if (apply)
                sel <= start_chan(apply_word);
            else if (accept_done && is_sweep(active))
                sel <= step_chan(active, sel);

            tag.valid <= accept_done;
            if (accept_done) begin
                tag.chan <= sel;
                tag.pair <= is_pair(active);
            end
        end
    end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              conv_start,
    input  logic              conv_done,
    output logic [CH_W-1:0]   mux_sel,
    output logic              mux_pair,
    output logic              done_valid,
    output logic [CH_W-1:0]   done_chan,
    output logic              done_pair
);
    logic       conv_busy;
    logic       apply;
    logic       pend_valid;
    ctrl_word_t active;
    ctrl_word_t apply_word;
    chan_tag_t  tag;

    adc_seq_conv_track u_track (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .busy       (conv_busy)
    );

    adc_seq_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_word    (ctrl_word_t'(wr_data)),
        .busy       (conv_busy),
        .conv_done  (conv_done),
        .active     (active),
        .apply      (apply),
        .apply_word (apply_word),
        .pend_valid (pend_valid)
    );

    adc_seq_ptr u_ptr (
        .clk        (clk),
        .rst        (rst),
        .apply      (apply),
        .apply_word (apply_word),
        .active     (active),
        .busy       (conv_busy),
        .conv_done  (conv_done),
        .sel        (mux_sel),
        .tag        (tag)
    );

    assign mux_pair   = is_pair(active);
    assign done_valid = tag.valid;
    assign done_chan  = tag.chan;
    assign done_pair  = tag.pair;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            conv_done,
    input logic            wr_en,
    input logic [CH_W-1:0] mux_sel,
    input logic            mux_pair,
    input logic            done_valid,
    input logic [CH_W-1:0] done_chan
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (mux_sel == '0 && !mux_pair && !done_valid));

    assert_pair_range_R2: assert property (@(posedge clk) disable iff (rst)
        mux_pair |-> (int'(mux_sel) < NUM_PAIRS));

    assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && conv_done && !wr_en) |=> ($stable(mux_sel) && !done_valid));

    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> ($stable(mux_sel) && $stable(mux_pair)));

    assert_tag_chan_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_done) |=> (done_valid && done_chan == $past(mux_sel)));

    assert_tag_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);
endmodule

bind adc_chan_seq adc_seq_checker chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (conv_busy),
    .conv_done  (conv_done),
    .wr_en      (wr_en),
    .mux_sel    (mux_sel),
    .mux_pair   (mux_pair),
    .done_valid (done_valid),
    .done_chan  (done_chan)
);

// File: tb/adc_chan_seq_test.sv
module adc_chan_seq_test;
    import adc_seq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic conv_start = 1'b0;
    logic conv_done = 1'b0;
    logic [CH_W-1:0] mux_sel;
    logic mux_pair, done_valid, done_pair;
    logic [CH_W-1:0] done_chan;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_chan_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .conv_start(conv_start), .conv_done(conv_done),
        .mux_sel(mux_sel), .mux_pair(mux_pair),
        .done_valid(done_valid), .done_chan(done_chan), .done_pair(done_pair)
    );

    // behavioural reference model
    int m_busy = 0, m_sel = 0, m_pair = 0, m_word = 0;
    int m_tv = 0, m_tch = 0, m_tp = 0;
    int pend_q[$];

    function automatic int lim_of(int w);
        return (((w >> 4) & 3) == 1) ? 1 : 3;
    endfunction

    task automatic m_load(int w);
        m_word = w;
        m_pair = (((w >> 4) & 3) == 1) ? 1 : 0;
        if (((w >> 2) & 3) == 3) m_sel = 0;
        else m_sel = (w & 3) & lim_of(w);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_sel = 0; m_pair = 0; m_word = 0;
            m_tv = 0; m_tch = 0; m_tp = 0;
            pend_q.delete();
        end else begin
            m_tv = 0;
            if (m_busy != 0 && conv_done) begin
                m_tv = 1; m_tch = m_sel; m_tp = m_pair;
                if (wr_en) m_load(int'(wr_data));
                else if (pend_q.size() > 0) m_load(pend_q[pend_q.size()-1]);
                else if (((m_word >> 2) & 3) == 3)
                    m_sel = (m_sel == ((m_word & 3) & lim_of(m_word))) ? 0 : m_sel + 1;
                pend_q.delete();
                m_busy = 0;
            end else if (m_busy != 0) begin
                if (wr_en) pend_q.push_back(int'(wr_data));
            end else begin
                if (wr_en) m_load(int'(wr_data));
                if (conv_start) m_busy = 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            check("R3 R5 R6 R8 mux_sel", int'(mux_sel), m_sel);
            check("R2 R8 mux_pair", int'(mux_pair), m_pair);
            check("R7 R9 done_valid", int'(done_valid), m_tv);
            if (m_tv != 0) begin
                check("R9 done_chan", int'(done_chan), m_tch);
                check("R9 done_pair", int'(done_pair), m_tp);
            end
        end
    end

    task automatic write(logic [5:0] w);
        wr_data = w; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic convert();
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mux_sel", int'(mux_sel), 0);
        check("R1 reset done_valid", int'(done_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset mux_pair", int'(mux_pair), 0);

        // R3 manual, single
        write(6'b00_00_10);
        check("R3 manual sel", int'(mux_sel), 2);
        convert();
        check("R9 tag chan", int'(done_chan), 2);
        check("R9 tag valid", int'(done_valid), 1);
        check("R6 manual hold", int'(mux_sel), 2);

        // R4 reserved codes
        write(6'b00_01_11);
        check("R4 code01", int'(mux_sel), 3);
        write(6'b00_10_01);
        check("R4 code10", int'(mux_sel), 1);

        // R2 pair manual
        write(6'b01_00_11);
        check("R2 pair flag", int'(mux_pair), 1);
        check("R3 pair sel", int'(mux_sel), 1);
        write(6'b10_00_11);
        check("R2 non-pair cfg", int'(mux_pair), 0);

        // R5 sweep single, final 2
        write(6'b00_11_10);
        check("R5 restart", int'(mux_sel), 0);
        convert(); check("R5 step1", int'(mux_sel), 1);
        convert(); check("R5 step2", int'(mux_sel), 2);
        convert(); check("R5 wrap", int'(mux_sel), 0);
        check("R9 tag final", int'(done_chan), 2);

        // R5 sweep pair, final 1
        write(6'b01_11_11);
        check("R5 pair start", int'(mux_sel), 0);
        convert(); check("R5 pair step", int'(mux_sel), 1);
        convert(); check("R5 pair wrap", int'(mux_sel), 0);
        check("R9 tag pair", int'(done_pair), 1);

        // R8 writes during a conversion
        conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
        write(6'b00_00_11);
        check("R8 hold sel", int'(mux_sel), 0);
        check("R8 hold pair", int'(mux_pair), 1);
        write(6'b00_00_01);
        conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
        conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        check("R8 last write wins", int'(mux_sel), 1);
        check("R8 pair after done", int'(mux_pair), 0);
        check("R9 tag old chan", int'(done_chan), 0);

        // R7 stray done while idle
        conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        check("R7 idle done no tag", int'(done_valid), 0);
        check("R7 idle done sel", int'(mux_sel), 1);

        // randomized traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 5) == 0);
            wr_data = 6'($urandom);
            conv_start = ($urandom_range(0, 2) == 0);
            conv_done = ($urandom_range(0, 2) == 0);
            @(negedge clk);
        end
        wr_en = 1'b0; conv_start = 1'b0; conv_done = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule